// File: doc/BRIEF.md
# Atomic Counting Semaphore Register

This block holds one shared semaphore word that several requesters update through single-cycle atomic increment and decrement operations. The value rests at all-ones (8'hFF by default) while the guarded resource is free. A requester claims the resource by strobing an increment. If that increment moves the value from all-ones to zero, the requester is the owner. Any other result means the resource is already taken. That requester must then strobe a decrement to undo its increment and try again later. The owner gives the resource back with a decrement. Every increment must be matched by a decrement.

A fixed-priority arbiter applies exactly one operation per clock. The read-modify-write of each served operation therefore cannot be split by another requester. A requester that is not served this cycle sees its stall line high and keeps its strobe up. The served requester receives a one-cycle response pulse that carries the updated value and a zero flag. The response appears in the same cycle the register shows the new value.

An occupancy state machine runs next to the counter and drives the busy output. It has three states:
- FREE: the value is all-ones.
- OWNED: the value is zero.
- SHARED: any other value.

Its transitions are:
- ACQUIRE: FREE to OWNED on an increment.
- STRAY_DEC: FREE to SHARED on an unpaired decrement.
- CONTEND: OWNED to SHARED on an increment.
- RELEASE: OWNED to FREE on a decrement.
- BACKOFF: SHARED to OWNED on a decrement that reaches zero.
- WRAP_FREE: SHARED to FREE on an increment that reaches all-ones.
- Any other operation in SHARED stays in SHARED.

Top module: `atomic_sem`

## Requirements
- R1: While `rst` is high at a rising clock edge, the semaphore loads all-ones (8'hFF), `busy` goes low and every `rsp_valid` bit goes low after that edge.
- R2: Bit i of `inc_req`/`dec_req` belongs to requester i. Among the requesters that strobe, only the lowest index is served in a cycle. In that same cycle, `stall` is high for every other strobing requester and low for the served one and for idle ones. After the edge, `rsp_valid` is one-hot on the served index for one cycle.
- R3: A served increment adds one to the value at the edge. The response shows the new value on `rsp_value`, and `rsp_zero` is 1 exactly when the new value is zero, which marks ownership.
- R4: A served decrement subtracts one from the value at the edge, with the same response format as R3.
- R5: A requester that raises both its increment and decrement strobe in one cycle is treated as an increment.
- R6: In a cycle with no strobe, the value does not change and no `rsp_valid` bit is raised.
- R7: `busy` is 0 exactly when the value is all-ones. Zero and every other value count as busy.
- R8: Counting wraps modulo 256 in both directions with no saturation: FF+1 gives 00, and 00-1 gives FF.
- R9: When two requesters increment together from free, the lower index gets zero (ownership) and the other gets 01 one cycle later. The other's back-off decrement returns the value to 00. The owner's release then returns it to FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inc_req | input | NUM_REQ | Increment strobe per requester |
| dec_req | input | NUM_REQ | Decrement strobe per requester |
| stall | output | NUM_REQ | Strobing but not served this cycle |
| rsp_valid | output | NUM_REQ | One-cycle response pulse to the served requester |
| rsp_value | output | SEM_W | Value after the served operation |
| rsp_zero | output | 1 | Served operation produced zero |
| sem_value | output | SEM_W | Current semaphore value |
| busy | output | 1 | Resource in use (value not all-ones) |

## Verification
`stall` is combinational, so the bench checks it in the same cycle the strobes are presented, shortly after driving them on the falling edge. The value, `busy` and the response fields each pass through one register. The bench checks them just after the next rising edge, while the strobes are still held. The next stimulus is applied only at the following falling edge. This places every R6 "nothing happened" check in the one cycle where a stray pulse would be visible.

// File: rtl/atomic_sem_pkg.sv
package atomic_sem_pkg;

    typedef enum logic [1:0] {
        SEM_FREE   = 2'd0,
        SEM_OWNED  = 2'd1,
        SEM_SHARED = 2'd2
    } sem_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2
    } sem_op_e;

endpackage

// File: rtl/sem_arbiter.sv
module sem_arbiter #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    logic [N:0] seen;

    // Lowest index wins: a bit is granted only if no lower bit requested.
    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_pri
            assign grant[i]  = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
        end
    endgenerate

endmodule

// File: rtl/sem_opsel.sv
module sem_opsel
    import atomic_sem_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] grant,
    input  logic [N-1:0] inc_req,
    output sem_op_e      op
);

    always_comb begin
        op = OP_NONE;
        if (|grant) begin
            // Increment strobe dominates when a requester raises both.
            op = (|(grant & inc_req)) ? OP_INC : OP_DEC;
        end
    end

endmodule

// File: rtl/sem_core.sv
module sem_core
    import atomic_sem_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  sem_op_e      op,
    output logic [W-1:0] value,
    output logic [W-1:0] next_value,
    output logic         busy
);

    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ZERO     = '0;
    localparam logic [W-1:0] ONE      = W'(1);

    logic [W-1:0] value_q;
    sem_state_e   state_q;
    sem_state_e   state_d;

    // Next value: modulo 2**W, no saturation.
    always_comb begin
        next_value = value_q;
        unique case (op)
            OP_INC:  next_value = value_q + ONE;
            OP_DEC:  next_value = value_q - ONE;
            default: next_value = value_q;
        endcase
    end

    // Occupancy transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEM_FREE: begin
                if (op == OP_INC)      state_d = SEM_OWNED;   // ACQUIRE
                else if (op == OP_DEC) state_d = SEM_SHARED;  // STRAY_DEC
            end
            SEM_OWNED: begin
                if (op == OP_INC)      state_d = SEM_SHARED;  // CONTEND
                else if (op == OP_DEC) state_d = SEM_FREE;    // RELEASE
            end
            SEM_SHARED: begin
                if (op == OP_INC && next_value == ALL_ONES)
                    state_d = SEM_FREE;                       // WRAP_FREE
                else if (op == OP_DEC && next_value == ZERO)
                    state_d = SEM_OWNED;                      // BACKOFF
            end
            default: state_d = SEM_FREE;
        endcase
    end

    // State and value registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEM_FREE;
            value_q <= ALL_ONES;
        end else begin
            state_q <= state_d;
            value_q <= next_value;
        end
    end

    // Outputs.
    always_comb begin
        value = value_q;
        busy  = (state_q != SEM_FREE);
    end

endmodule

// File: rtl/sem_rsp.sv
module sem_rsp #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] grant,
    input  logic [W-1:0] next_value,
    output logic [N-1:0] rsp_valid,
    output logic [W-1:0] rsp_value,
    output logic         rsp_zero
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_vld
            always_ff @(posedge clk) begin
                if (rst) rsp_valid[i] <= 1'b0;
                else     rsp_valid[i] <= grant[i];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_value <= '1;
            rsp_zero  <= 1'b0;
        end else if (|grant) begin
            rsp_value <= next_value;
            rsp_zero  <= (next_value == '0);
        end
    end

endmodule

// File: rtl/atomic_sem.sv
module atomic_sem
    import atomic_sem_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int SEM_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] inc_req,
    input  logic [NUM_REQ-1:0] dec_req,
    output logic [NUM_REQ-1:0] stall,
    output logic [NUM_REQ-1:0] rsp_valid,
    output logic [SEM_W-1:0]   rsp_value,
    output logic               rsp_zero,
    output logic [SEM_W-1:0]   sem_value,
    output logic               busy
);

    logic [NUM_REQ-1:0] req;
    logic [NUM_REQ-1:0] grant;
    logic [SEM_W-1:0]   next_value;
    sem_op_e            op;

    assign req   = inc_req | dec_req;
    assign stall = req & ~grant;

    sem_arbiter #(.N(NUM_REQ)) u_arb (
        .req   (req),
        .grant (grant)
    );

    sem_opsel #(.N(NUM_REQ)) u_opsel (
        .grant   (grant),
        .inc_req (inc_req),
        .op      (op)
    );

    sem_core #(.W(SEM_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .value      (sem_value),
        .next_value (next_value),
        .busy       (busy)
    );

    sem_rsp #(.N(NUM_REQ), .W(SEM_W)) u_rsp (
        .clk        (clk),
        .rst        (rst),
        .grant      (grant),
        .next_value (next_value),
        .rsp_valid  (rsp_valid),
        .rsp_value  (rsp_value),
        .rsp_zero   (rsp_zero)
    );

endmodule

// File: rtl/atomic_sem_chk.sv
module atomic_sem_chk #(
    parameter int N = 4,
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] inc_req,
    input logic [N-1:0] dec_req,
    input logic [N-1:0] stall,
    input logic [N-1:0] rsp_valid,
    input logic [W-1:0] rsp_value,
    input logic         rsp_zero,
    input logic [W-1:0] sem_value,
    input logic         busy
);

    localparam logic [W-1:0] ONE = W'(1);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (sem_value == '1) && !busy && (rsp_valid == '0)); // R1

    AST_ONE_SERVED: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_valid)); // R2

    AST_STALL_COUNT: assert property (@(posedge clk) disable iff (rst)
        (|(inc_req | dec_req)) |->
            ($countones(stall) == $countones(inc_req | dec_req) - 1)); // R2

    AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
        ((|inc_req) && !(|dec_req)) |=> (sem_value == $past(sem_value) + ONE)); // R3

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!(|inc_req) && (|dec_req)) |=> (sem_value == $past(sem_value) - ONE)); // R4

    AST_RSP_MATCH: assert property (@(posedge clk) disable iff (rst)
        (|rsp_valid) |-> (rsp_value == sem_value)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(|(inc_req | dec_req)) |=> ($stable(sem_value) && (rsp_valid == '0))); // R6

    AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (rst)
        busy == (sem_value != '1)); // R7

endmodule

bind atomic_sem atomic_sem_chk #(.N(NUM_REQ), .W(SEM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .inc_req   (inc_req),
    .dec_req   (dec_req),
    .stall     (stall),
    .rsp_valid (rsp_valid),
    .rsp_value (rsp_value),
    .rsp_zero  (rsp_zero),
    .sem_value (sem_value),
    .busy      (busy)
);

// File: tb/atomic_sem_tb.sv
module atomic_sem_tb;

    localparam int N        = 4;
    localparam int W        = 8;
    localparam int CLK_HALF = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] inc_req = '0;
    logic [N-1:0] dec_req = '0;
    logic [N-1:0] stall;
    logic [N-1:0] rsp_valid;
    logic [W-1:0] rsp_value;
    logic         rsp_zero;
    logic [W-1:0] sem_value;
    logic         busy;

    int           checks = 0;
    int           errors = 0;
    bit           done   = 1'b0;
    logic [W-1:0] exp_val = 8'hFF;

    always #CLK_HALF clk = ~clk;

    atomic_sem #(.NUM_REQ(N), .SEM_W(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .inc_req   (inc_req),
        .dec_req   (dec_req),
        .stall     (stall),
        .rsp_valid (rsp_valid),
        .rsp_value (rsp_value),
        .rsp_zero  (rsp_zero),
        .sem_value (sem_value),
        .busy      (busy)
    );

    task automatic check(input string rq, input string nm,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, nm, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; inc_req = '0; dec_req = '0;
        repeat (2) @(posedge clk);
        #1;
        exp_val = 8'hFF;
        check("R1", "sem_value", 32'(sem_value), 32'hFF);
        check("R1", "busy", 32'(busy), 0);
        check("R1", "rsp_valid", 32'(rsp_valid), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Present strobes for one cycle; check stall in-cycle, results after the edge.
    task automatic step(input logic [N-1:0] inc, input logic [N-1:0] dec,
                        input string tag);
        logic [N-1:0] req;
        logic [N-1:0] g;
        @(negedge clk);
        inc_req = inc; dec_req = dec;
        #1;
        req = inc | dec;
        g   = req & (~req + 1'b1);
        check("R2", "stall", 32'(stall), 32'(req & ~g));
        @(posedge clk);
        #1;
        if (g != '0) begin
            if ((g & inc) != '0) exp_val = exp_val + 8'd1;
            else                 exp_val = exp_val - 8'd1;
        end
        check("R2", "rsp_valid", 32'(rsp_valid), 32'(g));
        if (g != '0) begin
            check(tag, "rsp_value", 32'(rsp_value), 32'(exp_val));
            check("R3", "rsp_zero", 32'(rsp_zero), 32'(exp_val == 8'h00));
        end
        check(tag, "sem_value", 32'(sem_value), 32'(exp_val));
        check("R7", "busy", 32'(busy), 32'(exp_val != 8'hFF));
    endtask

    function automatic logic [N-1:0] low_bit(input logic [N-1:0] m);
        return m & (~m + 1'b1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();

        // R2 / R3 arbitration sweep with increments, each undone by the winner
        for (int m = 1; m < (1 << N); m++) begin
            step(N'(m), '0, "R3");
            step('0, low_bit(N'(m)), "R4");
        end

        // R2 / R4 arbitration sweep with decrements, each undone
        for (int m = 1; m < (1 << N); m++) begin
            step('0, N'(m), "R4");
            step(low_bit(N'(m)), '0, "R3");
        end

        // R5 both strobes from one requester count as an increment
        for (int i = 0; i < N; i++) begin
            step(N'(1 << i), N'(1 << i), "R5");
            step('0, N'(1 << i), "R4");
        end
        // R5 with a higher requester decrementing alongside
        step(4'b0001, 4'b0011, "R5");
        step('0, 4'b0001, "R4");

        // R6 idle cycles: nothing changes, no pulse
        for (int k = 0; k < 4; k++) step('0, '0, "R6");
        step(4'b0100, '0, "R3");
        step('0, '0, "R6");
        step('0, '0, "R6");
        step('0, 4'b0100, "R4");

        // R8 full wrap upward then downward
        for (int k = 0; k < 256; k++) step(4'b0100, '0, "R8");
        for (int k = 0; k < 256; k++) step('0, 4'b1000, "R8");

        // R9 contention, back-off and release
        step(4'b0011, '0, "R9");
        check("R9", "owner_zero", 32'(rsp_zero), 1);
        step(4'b0010, '0, "R9");
        check("R9", "loser_value", 32'(rsp_value), 32'h01);
        check("R9", "loser_zero", 32'(rsp_zero), 0);
        step('0, 4'b0010, "R9");
        check("R9", "after_backoff", 32'(sem_value), 32'h00);
        step('0, 4'b0001, "R9");
        check("R9", "after_release", 32'(sem_value), 32'hFF);

        // R1 reset from a busy state
        step(4'b1000, '0, "R3");
        step(4'b1000, '0, "R3");
        do_reset();
        step('0, '0, "R6");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule